// File: doc/BRIEF.md
# Bus Error Source Status Latch

This block keeps a record of which requester caused the most recent bus error. An exception handler reads that record back through a small register port. Each source, such as a local memory timeout or an error returned on a system-bus cycle, drives a one-cycle pulse. On the clock edge after the pulse, the block replaces the recorded source vector with the sources that pulsed. It keeps no copy of the earlier error. If a second error arrives before software reads the status, it hides the first, and software must allow for that.

A separate pending flag is set by every error and cleared when the CPU acknowledges a bus error. Software can compare this flag against its own exception entry to see that the status changed in between. An enable bit turns every bus error into an interrupt request at level 7, the non-maskable priority. The request stays up until software clears its status bit or clears the enable.

Top module: `berr_status_latch`

## Requirements
- R1: After a synchronous active-low reset, the source bits, the summary bit, the pending flag, the interrupt status, the enable, `irq_req_o`, `irq_level_o` and `reg_rdata_o` are all zero.
- R2: A pulse on `berr_src_i[i]` sets source bit i, seen on `src_status_o` and at status bit i, on the next clock edge.
- R3: Any cycle with at least one source pulsing replaces the whole source vector with the pulsing sources. Bits of earlier errors are lost, and simultaneous pulses set several bits.
- R4: A write to address 0 (status) clears each source bit whose write-data bit is 1. Write-data bits that are 0 leave their source bits unchanged.
- R5: When a status clear and a new error fall in the same cycle, the new error's source bits end up set.
- R6: The summary bit (status bit NUM_SRC, also `any_berr_o`) is the OR of all source bits.
- R7: Address 1 bit 0 is the interrupt enable. While it is 1, a bus error sets the interrupt status (status bit NUM_SRC+1). On the next edge `irq_req_o` goes high with `irq_level_o` = 7.
- R8: The request stays high until a status write with a 1 in bit NUM_SRC+1 arrives, or the enable is written 0. Clearing only source bits, or acknowledging, does not drop it. With the enable at 0, errors raise no request. `irq_level_o` is 0 whenever there is no request.
- R9: The pending flag (status bit NUM_SRC+2) is set by any error and cleared by `cpu_berr_ack_i`. An error in the same cycle as the acknowledge leaves it set. Status writes do not change it.
- R10: A cycle with `reg_rd_i` high loads the addressed register into `reg_rdata_o` on the next edge, with unused bits zero. `reg_rdata_o` holds its value in other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| berr_src_i | input | NUM_SRC | Per-source bus error pulses |
| cpu_berr_ack_i | input | 1 | CPU has taken a bus error exception |
| reg_addr_i | input | 1 | 0 = status, 1 = control |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| src_status_o | output | NUM_SRC | Recorded source bits |
| any_berr_o | output | 1 | OR of source bits |
| irq_req_o | output | 1 | Bus error interrupt request |
| irq_level_o | output | 3 | Request level, 7 or 0 |

## Verification
The bench drives an error with a status clear in the same cycle. A design that let the clear win would lose the new source. It lands a second error on a live record and checks that the first source's bit is gone, which catches a design that ORs errors together. An error and an acknowledge in the same cycle would leave the pending flag clear if the priority were reversed. Clearing only source bits must leave the interrupt request up, and clearing the enable must drop it. A design that tied the request to the summary bit, or ignored the enable, fails these checks.

// File: rtl/berr_pkg.sv
package berr_pkg;
    localparam logic       ADDR_STATUS = 1'b0;
    localparam logic       ADDR_CTRL   = 1'b1;
    localparam logic [2:0] IRQ_LVL_NMI = 3'd7;
    localparam logic [2:0] IRQ_LVL_OFF = 3'd0;
endpackage

// File: rtl/berr_src_capture.sv
module berr_src_capture #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] err_i,
    input  logic               ack_i,
    input  logic               clr_we_i,
    input  logic [NUM_SRC-1:0] clr_mask_i,
    output logic [NUM_SRC-1:0] src_o,
    output logic               pend_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] src;
        logic               pend;
    } cap_t;

    cap_t st_d, st_q;
    logic hit;

    always_comb begin
        hit  = |err_i;
        st_d = st_q;
        if (clr_we_i) st_d.src = st_q.src & ~clr_mask_i;
        if (hit)      st_d.src = err_i;      // newest error replaces record
        if (ack_i)    st_d.pend = 1'b0;
        if (hit)      st_d.pend = 1'b1;      // error beats acknowledge
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_o  = st_q.src;
    assign pend_o = st_q.pend;

    p_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_i) |=> (src_o == $past(err_i)));
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && !(|err_i)) |=> (src_o == ($past(src_o) & ~$past(clr_mask_i))));
    p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !(|err_i)) |=> !pend_o);
    p_pend_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_i) |=> pend_o);
endmodule

// File: rtl/berr_irq_ctrl.sv
module berr_irq_ctrl
    import berr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       err_any_i,
    input  logic       en_we_i,
    input  logic       en_wdata_i,
    input  logic       sts_clr_i,
    output logic       en_o,
    output logic       sts_o,
    output logic       irq_req_o,
    output logic [2:0] irq_level_o
);
    typedef struct packed {
        logic en;
        logic sts;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_we_i)              st_d.en  = en_wdata_i;
        if (sts_clr_i)            st_d.sts = 1'b0;
        if (err_any_i && st_q.en) st_d.sts = 1'b1;
        if (!st_d.en)             st_d.sts = 1'b0;   // disabling withdraws request
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o        = st_q.en;
    assign sts_o       = st_q.sts;
    assign irq_req_o   = st_q.sts;
    assign irq_level_o = st_q.sts ? IRQ_LVL_NMI : IRQ_LVL_OFF;

    p_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_any_i && en_o && !en_we_i) |=> irq_req_o);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && !sts_clr_i && !en_we_i) |=> irq_req_o);
    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |-> !irq_req_o);
endmodule

// File: rtl/berr_status_latch.sv
module berr_status_latch
    import berr_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] berr_src_i,
    input  logic               cpu_berr_ack_i,
    input  logic               reg_addr_i,
    input  logic               reg_wr_i,
    input  logic               reg_rd_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic [NUM_SRC-1:0] src_status_o,
    output logic               any_berr_o,
    output logic               irq_req_o,
    output logic [2:0]         irq_level_o
);
    localparam int BIT_ANY  = NUM_SRC;
    localparam int BIT_IRQ  = NUM_SRC + 1;
    localparam int BIT_PEND = NUM_SRC + 2;
    localparam int STAT_W   = NUM_SRC + 3;

    logic               wr_status, wr_ctrl;
    logic [NUM_SRC-1:0] src;
    logic               pend, irq_en, irq_sts;
    logic [STAT_W-1:0]  stat_word;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  rdata_d, rdata_q;
    logic               unused_wdata;

    assign wr_status    = reg_wr_i && (reg_addr_i == ADDR_STATUS);
    assign wr_ctrl      = reg_wr_i && (reg_addr_i == ADDR_CTRL);
    assign unused_wdata = ^reg_wdata_i;

    berr_src_capture #(.NUM_SRC(NUM_SRC)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_i      (berr_src_i),
        .ack_i      (cpu_berr_ack_i),
        .clr_we_i   (wr_status),
        .clr_mask_i (reg_wdata_i[NUM_SRC-1:0]),
        .src_o      (src),
        .pend_o     (pend)
    );

    berr_irq_ctrl u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_any_i   (|berr_src_i),
        .en_we_i     (wr_ctrl),
        .en_wdata_i  (reg_wdata_i[0]),
        .sts_clr_i   (wr_status && reg_wdata_i[BIT_IRQ]),
        .en_o        (irq_en),
        .sts_o       (irq_sts),
        .irq_req_o   (irq_req_o),
        .irq_level_o (irq_level_o)
    );

    always_comb begin
        stat_word           = '0;
        stat_word[NUM_SRC-1:0] = src;
        stat_word[BIT_ANY]  = |src;
        stat_word[BIT_IRQ]  = irq_sts;
        stat_word[BIT_PEND] = pend;
        rd_mux = (reg_addr_i == ADDR_CTRL) ? DATA_W'(irq_en) : DATA_W'(stat_word);
        rdata_d = reg_rd_i ? rd_mux : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign reg_rdata_o  = rdata_q;
    assign src_status_o = src;
    assign any_berr_o   = |src;

    p_any_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|berr_src_i) |=> any_berr_o);
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_i |=> $stable(reg_rdata_o));
    p_lvl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req_o |-> (irq_level_o == 3'd0));
endmodule

// File: tb/tb_berr_status_latch.sv
module tb_berr_status_latch;
    localparam int N = 4;
    localparam int W = 8;

    logic         clk = 0;
    logic         rst_n = 0;
    logic [N-1:0] berr = '0;
    logic         ack = 0, addr = 0, wr = 0, rd = 0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic [N-1:0] src;
    logic         any, irq;
    logic [2:0]   lvl;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    berr_status_latch #(.NUM_SRC(N), .DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .berr_src_i(berr), .cpu_berr_ack_i(ack),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .src_status_o(src), .any_berr_o(any),
        .irq_req_o(irq), .irq_level_o(lvl)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic idle();
        berr = '0; ack = 0; wr = 0; rd = 0; addr = 0; wdata = '0;
    endtask

    task automatic pulse(logic [N-1:0] v);
        berr = v; step(); idle();
    endtask

    task automatic wreg(logic a, logic [W-1:0] d);
        addr = a; wdata = d; wr = 1; step(); idle();
    endtask

    task automatic rreg(logic a, output logic [W-1:0] d);
        addr = a; rd = 1; step(); d = rdata; idle();
    endtask

    // status layout: [3:0] sources, 4 any, 5 irq status, 6 pending
    task automatic t_reset();
        rst_n = 0; idle(); step(); step(); rst_n = 1; step();
        chk("R1 src", src, 0); chk("R1 any", any, 0);
        chk("R1 irq", irq, 0); chk("R1 lvl", lvl, 0); chk("R1 rdata", rdata, 0);
    endtask

    task automatic t_single();
        logic [W-1:0] d;
        pulse(4'b0100);
        chk("R2 src", src, 4'b0100); chk("R6 any", any, 1);
        rreg(0, d); chk("R10 status read", d, 8'h54);
        step(); chk("R10 hold", rdata, 8'h54);
    endtask

    task automatic t_overwrite();
        pulse(4'b0001); chk("R3 overwrite", src, 4'b0001);
        pulse(4'b1010); chk("R3 multi", src, 4'b1010);
    endtask

    task automatic t_w1c();
        logic [W-1:0] d;
        wreg(0, 8'h02); chk("R4 clear one", src, 4'b1000);
        wreg(0, 8'h00); chk("R4 zero no effect", src, 4'b1000);
        wreg(0, 8'h48); chk("R6 any clear", any, 0);
        rreg(0, d); chk("R9 pend survives write", d, 8'h40);
    endtask

    task automatic t_ack();
        logic [W-1:0] d;
        ack = 1; step(); idle();
        rreg(0, d); chk("R9 ack clears", d, 8'h00);
        berr = 4'b0001; ack = 1; step(); idle();
        rreg(0, d); chk("R9 err beats ack", d, 8'h51);
    endtask

    task automatic t_clr_race();
        addr = 0; wdata = 8'h01; wr = 1; berr = 4'b0001; step(); idle();
        chk("R5 same bit", src, 4'b0001);
        addr = 0; wdata = 8'h0F; wr = 1; berr = 4'b0100; step(); idle();
        chk("R5 other bit", src, 4'b0100);
    endtask

    task automatic t_irq();
        logic [W-1:0] d;
        pulse(4'b0001); chk("R8 no irq disabled", irq, 0);
        wreg(1, 8'h01); rreg(1, d); chk("R10 ctrl read", d, 8'h01);
        pulse(4'b0010); chk("R7 irq", irq, 1); chk("R7 lvl", lvl, 3'd7);
        wreg(0, 8'h0F); chk("R8 src clear keeps irq", irq, 1);
        ack = 1; step(); idle(); chk("R8 ack keeps irq", irq, 1);
        wreg(0, 8'h20); chk("R8 sts clear", irq, 0); chk("R8 lvl 0", lvl, 0);
        pulse(4'b1000); chk("R7 irq again", irq, 1);
        wreg(1, 8'h00); chk("R8 disable drops", irq, 0);
        pulse(4'b0100); chk("R8 stays off", irq, 0);
        wreg(1, 8'h01); chk("R8 reenable no stale", irq, 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_overwrite();
        t_w1c();
        t_ack();
        t_clr_race();
        t_irq();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule